// File: doc/BRIEF.md
# Single-Vote Ballot Control Unit

This unit runs a four-candidate voting station. A mode input picks between voting and result operation. In voting mode, a voter presents a 6-bit identifier in obscured form and presses confirm. The unit removes the obscuring with a fixed XOR key and looks the identifier up in a small enrolment roll that is set by parameters. It refuses identifiers that are not on the roll and voters who have already cast a ballot. After an accepted identifier, a second confirm, given with exactly one candidate line high, casts the ballot. That candidate's tally and the running total each go up by one, and the voter's status flag is set so the same voter cannot vote again.

Every attempt ends in a one-cycle accept pulse or a one-cycle reject pulse with a reason code. In result mode the tallies, the total, the leading candidate and a tie indication stay at zero until an unlock input has been seen. That unlock input comes from an external password checker. Debouncing, display driving and password checking are done outside this unit.

Top module: `ballot_ctrl`

## Requirements
- R1: `mode_vote`=1 selects voting operation and `mode_vote`=0 selects result operation. In result operation `confirm` is ignored: there is no pulse and no tally change.
- R2: The identifier is recovered as `voter_id` XOR KEY (default KEY 6'h2A). It is accepted only if it equals a roll entry (default roll 3, 9, 14, 21, 27, 34, 45, 58). Otherwise `ack_rej` pulses with `rej_code`=1 and nothing else changes.
- R3: An enrolled voter whose status flag is already set is refused with `ack_rej` and `rej_code`=2.
- R4: Voting takes two steps. The first `confirm` validates the identifier. The second `confirm`, with `cand_sel` one-hot (bit i selects candidate i), adds one to candidate i's tally and one to the total, and pulses `ack_ok`.
- R5: If zero or several `cand_sel` bits are high at the second `confirm`, the unit pulses `ack_rej` with `rej_code`=3. No tally changes, the voter's flag stays clear, and the unit waits for a new identifier.
- R6: An accepted ballot sets that voter's status flag, and the flag stays set until reset.
- R7: `ack_ok` and `ack_rej` are one-cycle pulses that appear in the cycle after the clock edge that samples `confirm`. They are never high together, and `rej_code` is 0 whenever `ack_rej` is low.
- R8: `res_valid`, `res_counts`, `res_total`, `res_winner` and `res_tie` are all zero unless `mode_vote`=0 and unlock has been latched. Unlock is latched at a clock edge where `unlock`=1 in result mode. The latch is cleared whenever `mode_vote`=1.
- R9: `res_winner` is the candidate with the highest tally, and the lowest index wins a tie. `res_tie` is 1 when two or more candidates share the highest tally, which includes the case where all tallies are zero.
- R10: Leaving voting mode between the two confirms abandons the ballot with no pulse and no flag change.
- R11: A synchronous active-low reset clears all tallies, all status flags, the unlock latch, the ballot step and the pulses.
- R12: The total always equals the sum of the four candidate tallies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_vote | input | 1 | 1 = voting, 0 = result |
| voter_id | input | 6 | Obscured voter identifier |
| confirm | input | 1 | Confirm strobe (one cycle) |
| cand_sel | input | 4 | Candidate select lines, bit i = candidate i |
| unlock | input | 1 | Result unlock from external checker |
| ack_ok | output | 1 | Ballot accepted pulse |
| ack_rej | output | 1 | Attempt refused pulse |
| rej_code | output | 2 | Reason: 1 bad id, 2 already voted, 3 bad selection |
| res_valid | output | 1 | Results visible |
| res_counts | output | 32 | Tallies, candidate i at bits [8i+7:8i] |
| res_total | output | 10 | Total accepted ballots |
| res_winner | output | 2 | Leading candidate index |
| res_tie | output | 1 | Highest tally shared |

## Verification
The hardest state to reach is a second confirm that follows an accepted identifier but is unusual in some way. It may come with a bad selection, after a mode change, or for a voter who was refused a moment earlier. The stimulus builds each of these as explicit two-step sequences and then retries the same voter, which shows that the status flag was left clear. Tie resolution is reached by spreading ballots evenly across two candidates and then breaking the tie, with results unlocked in between.

// File: rtl/ballot_pkg.sv
// Shared types for the ballot control unit.
// Assumes four candidates; reason codes are visible at the top's ports.
package ballot_pkg;
    localparam int NCAND = 4;

    typedef enum logic [1:0] {
        RJ_NONE = 2'd0,
        RJ_ID   = 2'd1,
        RJ_DONE = 2'd2,
        RJ_SEL  = 2'd3
    } rej_e;

    typedef enum logic {
        ST_ID   = 1'b0,
        ST_PICK = 1'b1
    } step_e;
endpackage

// File: rtl/ballot_roll.sv
// Enrolment roll: de-obscures the presented identifier with a fixed XOR key,
// matches it against NV parameter entries (lowest index wins on duplicates),
// and keeps one voted flag per entry. Assumes mark is asserted only for a
// slot that previously matched and was not yet voted.
module ballot_roll #(
    parameter int          NV   = 8,
    parameter int          IW   = 6,
    parameter logic [IW-1:0] KEY = 6'h2A,
    parameter logic [NV*IW-1:0] ROLL = {6'd58, 6'd45, 6'd34, 6'd27,
                                        6'd21, 6'd14, 6'd9,  6'd3},
    localparam int SW = (NV > 1) ? $clog2(NV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] id_in,
    input  logic          mark,
    input  logic [SW-1:0] mark_slot,
    output logic          hit,
    output logic [SW-1:0] hit_slot,
    output logic          hit_voted
);
    logic [IW-1:0] plain;
    logic [NV-1:0] match;
    logic [NV-1:0] voted_q;

    assign plain = id_in ^ KEY;

    // per-entry comparators
    for (genvar g = 0; g < NV; g++) begin : g_cmp
        assign match[g] = (plain == ROLL[g*IW +: IW]);
    end

    // priority pick of the lowest matching slot
    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int i = NV - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_slot = SW'(i);
            end
        end
        hit_voted = voted_q[hit_slot] & hit;
    end

    // voted flags: set on accepted ballot, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)    voted_q <= '0;
        else if (mark) voted_q[mark_slot] <= 1'b1;
    end

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((voted_q & $past(voted_q)) == $past(voted_q)));
    // R3
    mark_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mark |-> !voted_q[mark_slot]);
endmodule

// File: rtl/ballot_tally.sv
// Candidate tallies, running total and leader selection.
// Assumes inc_sel is one-hot whenever inc is high; ties go to the lowest index.
module ballot_tally #(
    parameter int NC = 4,
    parameter int CW = 8,
    localparam int TW = CW + $clog2(NC),
    localparam int XW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inc,
    input  logic [NC-1:0]  inc_sel,
    output logic [NC*CW-1:0] cnt_flat,
    output logic [TW-1:0]  total,
    output logic [XW-1:0]  best_idx,
    output logic           tie
);
    logic [CW-1:0] cnt_q [NC];
    logic [TW-1:0] total_q;

    // one counter per candidate
    for (genvar g = 0; g < NC; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n)                 cnt_q[g] <= '0;
            else if (inc && inc_sel[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
        end
        assign cnt_flat[g*CW +: CW] = cnt_q[g];
    end

    // running total of accepted ballots
    always_ff @(posedge clk) begin
        if (!rst_n)   total_q <= '0;
        else if (inc) total_q <= total_q + 1'b1;
    end
    assign total = total_q;

    // leader by strict comparison, then count holders of the maximum
    always_comb begin
        logic [CW-1:0] best;
        int            nmax;
        best     = cnt_q[0];
        best_idx = '0;
        for (int i = 1; i < NC; i++) begin
            if (cnt_q[i] > best) begin
                best     = cnt_q[i];
                best_idx = XW'(i);
            end
        end
        nmax = 0;
        for (int i = 0; i < NC; i++) if (cnt_q[i] == best) nmax++;
        tie = (nmax > 1);
    end

    // R12
    total_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        total_q == (TW'(cnt_q[0]) + TW'(cnt_q[1]) + TW'(cnt_q[2]) + TW'(cnt_q[3])));
    // R9
    leader_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[best_idx] >= cnt_q[0] && cnt_q[best_idx] >= cnt_q[NC-1]);
endmodule

// File: rtl/ballot_ctrl.sv
// Ballot control unit top: two-step confirm sequencing, accept/reject pulses
// with reason codes, unlock latch and masking of results. Assumes confirm is
// already debounced to one cycle and unlock comes from an external checker.
module ballot_ctrl
    import ballot_pkg::*;
#(
    parameter int NV = 8,
    parameter int IW = 6,
    parameter int CW = 8,
    parameter logic [IW-1:0] KEY = 6'h2A,
    parameter logic [NV*IW-1:0] ROLL = {6'd58, 6'd45, 6'd34, 6'd27,
                                        6'd21, 6'd14, 6'd9,  6'd3},
    localparam int SW = (NV > 1) ? $clog2(NV) : 1,
    localparam int TW = CW + $clog2(NCAND)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_vote,
    input  logic [IW-1:0]       voter_id,
    input  logic                confirm,
    input  logic [NCAND-1:0]    cand_sel,
    input  logic                unlock,
    output logic                ack_ok,
    output logic                ack_rej,
    output logic [1:0]          rej_code,
    output logic                res_valid,
    output logic [NCAND*CW-1:0] res_counts,
    output logic [TW-1:0]       res_total,
    output logic [1:0]          res_winner,
    output logic                res_tie
);
    step_e         step_q;
    logic [SW-1:0] slot_q;
    logic          unl_q;
    rej_e          code_q;
    logic          hit, hit_voted, sel_one, cast;
    logic [SW-1:0] hit_slot;
    logic [NCAND*CW-1:0] cnt_flat;
    logic [TW-1:0] total;
    logic [1:0]    best_idx;
    logic          tie;

    assign sel_one = (cand_sel != '0) && ((cand_sel & (cand_sel - 1'b1)) == '0);
    assign cast    = mode_vote && confirm && (step_q == ST_PICK) && sel_one;

    ballot_roll #(.NV(NV), .IW(IW), .KEY(KEY), .ROLL(ROLL)) u_roll (
        .clk(clk), .rst_n(rst_n), .id_in(voter_id),
        .mark(cast), .mark_slot(slot_q),
        .hit(hit), .hit_slot(hit_slot), .hit_voted(hit_voted)
    );

    ballot_tally #(.NC(NCAND), .CW(CW)) u_tally (
        .clk(clk), .rst_n(rst_n), .inc(cast), .inc_sel(cand_sel),
        .cnt_flat(cnt_flat), .total(total), .best_idx(best_idx), .tie(tie)
    );

    // ballot sequencing and one-cycle outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= ST_ID;
            slot_q  <= '0;
            ack_ok  <= 1'b0;
            ack_rej <= 1'b0;
            code_q  <= RJ_NONE;
        end else begin
            ack_ok  <= 1'b0;
            ack_rej <= 1'b0;
            code_q  <= RJ_NONE;
            if (!mode_vote) begin
                step_q <= ST_ID;
            end else if (confirm) begin
                if (step_q == ST_ID) begin
                    if (!hit) begin
                        ack_rej <= 1'b1;
                        code_q  <= RJ_ID;
                    end else if (hit_voted) begin
                        ack_rej <= 1'b1;
                        code_q  <= RJ_DONE;
                    end else begin
                        step_q <= ST_PICK;
                        slot_q <= hit_slot;
                    end
                end else begin
                    step_q <= ST_ID;
                    if (sel_one) begin
                        ack_ok <= 1'b1;
                    end else begin
                        ack_rej <= 1'b1;
                        code_q  <= RJ_SEL;
                    end
                end
            end
        end
    end
    assign rej_code = code_q;

    // unlock latch, dropped whenever voting resumes
    always_ff @(posedge clk) begin
        if (!rst_n)         unl_q <= 1'b0;
        else if (mode_vote) unl_q <= 1'b0;
        else if (unlock)    unl_q <= 1'b1;
    end

    // results masked until unlocked in result mode
    always_comb begin
        res_valid  = !mode_vote && unl_q;
        res_counts = res_valid ? cnt_flat : '0;
        res_total  = res_valid ? total    : '0;
        res_winner = res_valid ? best_idx : '0;
        res_tie    = res_valid && tie;
    end

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_ok && ack_rej));
    // R7
    code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_rej |-> (rej_code == 2'd0));
    // R4
    total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ok |-> (total == $past(total) + 1'b1));
    // R8
    unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unl_q) |-> ($past(unlock) && !$past(mode_vote)));
endmodule

// File: tb/sim_ballot_ctrl.sv
module sim_ballot_ctrl;
    localparam int PER = 10;
    localparam int KEYV = 42;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       mode_vote = 1;
    logic [5:0] voter_id = 0;
    logic       confirm = 0;
    logic [3:0] cand_sel = 0;
    logic       unlock = 0;
    logic       ack_ok, ack_rej, res_valid, res_tie;
    logic [1:0] rej_code, res_winner;
    logic [31:0] res_counts;
    logic [9:0] res_total;

    int total_n = 0, bad_n = 0, cycles = 0;
    int roll [8] = '{3, 9, 14, 21, 27, 34, 45, 58};

    // reference model state
    int m_cnt [4];
    bit m_flag [8];
    bit m_unl, m_pick, m_ok, m_rej;
    int m_slot, m_code;

    always #(PER/2) clk = ~clk;

    ballot_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mode_vote(mode_vote), .voter_id(voter_id),
        .confirm(confirm), .cand_sel(cand_sel), .unlock(unlock),
        .ack_ok(ack_ok), .ack_rej(ack_rej), .rej_code(rej_code),
        .res_valid(res_valid), .res_counts(res_counts), .res_total(res_total),
        .res_winner(res_winner), .res_tie(res_tie)
    );

    function automatic int lookup(int obs);
        for (int i = 0; i < 8; i++) if ((obs ^ KEYV) == roll[i]) return i;
        return -1;
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            foreach (m_flag[i]) m_flag[i] = 0;
            m_unl = 0; m_pick = 0; m_ok = 0; m_rej = 0; m_code = 0; m_slot = 0;
        end else begin
            m_ok = 0; m_rej = 0; m_code = 0;
            if (!mode_vote) m_pick = 0;
            else if (confirm) begin
                if (!m_pick) begin
                    int s;
                    s = lookup(voter_id);
                    if (s < 0) begin m_rej = 1; m_code = 1; end
                    else if (m_flag[s]) begin m_rej = 1; m_code = 2; end
                    else begin m_pick = 1; m_slot = s; end
                end else begin
                    m_pick = 0;
                    if ($countones(cand_sel) == 1) begin
                        for (int i = 0; i < 4; i++) if (cand_sel[i]) m_cnt[i]++;
                        m_flag[m_slot] = 1;
                        m_ok = 1;
                    end else begin m_rej = 1; m_code = 3; end
                end
            end
            if (mode_vote) m_unl = 0;
            else if (unlock) m_unl = 1;
        end
    end

    task automatic check(int act, int exp, string tag);
        total_n++;
        if (act != exp) begin
            bad_n++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare outputs with the model on every cycle, after the edge settles
    always @(posedge clk) begin
        #(PER/4);
        if (rst_n) begin
            bit vis;
            int best, wi, nmax, tot;
            vis = !mode_vote && m_unl;
            best = m_cnt[0]; wi = 0; tot = 0; nmax = 0;
            for (int i = 1; i < 4; i++) if (m_cnt[i] > best) begin best = m_cnt[i]; wi = i; end
            for (int i = 0; i < 4; i++) begin tot += m_cnt[i]; if (m_cnt[i] == best) nmax++; end
            check(ack_ok, m_ok, "R4/R7 ack_ok");
            check(ack_rej, m_rej, "R7 ack_rej");
            check(rej_code, m_code, "R2/R3/R5 rej_code");
            check(res_valid, vis, "R8 res_valid");
            for (int i = 0; i < 4; i++)
                check(res_counts[i*8 +: 8], vis ? m_cnt[i] : 0, "R4/R8 count");
            check(res_total, vis ? tot : 0, "R12 total");
            check(res_winner, vis ? wi : 0, "R9 winner");
            check(res_tie, vis && (nmax > 1), "R9 tie");
        end
    end

    task automatic cyc(bit m, int id, bit c, int sel, bit u);
        @(negedge clk);
        mode_vote = m; voter_id = 6'(id); confirm = c; cand_sel = 4'(sel); unlock = u;
    endtask

    task automatic present(int v);
        cyc(1, roll[v] ^ KEYV, 1, 0, 0);
        cyc(1, 0, 0, 0, 0);
    endtask

    task automatic pick(int sel);
        cyc(1, 0, 1, sel, 0);
        cyc(1, 0, 0, 0, 0);
    endtask

    task automatic vote(int v, int sel);
        present(v);
        pick(sel);
    endtask

    task automatic open_results();
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        @(negedge clk);
        check(ack_ok, 0, "R11 ack_ok after reset");
        check(ack_rej, 0, "R11 ack_rej after reset");
        open_results();
        check(res_total, 0, "R11 total after reset");
        check(res_tie, 1, "R9 all-zero tie");
        // R4 plain vote, voter 0 for candidate 2
        vote(0, 4'b0100);
        // R3 second attempt by voter 0
        present(0);
        // R2 unknown identifier (plain 5)
        cyc(1, 5 ^ KEYV, 1, 0, 0); cyc(1, 0, 0, 0, 0);
        // R2 raw roll value without obscuring is not enrolled
        cyc(1, 9, 1, 0, 0); cyc(1, 0, 0, 0, 0);
        // R5 no selection, then two selections, then the same voter succeeds
        vote(1, 4'b0000);
        vote(1, 4'b0110);
        vote(1, 4'b0010);
        // R10 abandon mid-ballot by leaving voting mode
        present(2);
        cyc(0, 0, 1, 4'b0001, 0);
        cyc(1, 0, 1, 4'b0001, 0);   // now treated as an identifier step
        cyc(1, 0, 0, 0, 0);
        vote(2, 4'b0010);
        vote(3, 4'b0100);
        // R8 locked result mode hides tallies
        cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
        check(res_valid, 0, "R8 locked");
        check(res_total, 0, "R8 total hidden");
        // R1 confirm in result mode is ignored
        cyc(0, roll[4] ^ KEYV, 1, 0, 0); cyc(0, 0, 1, 4'b0001, 0);
        open_results();
        check(res_total, 4, "R12 total four ballots");
        check(res_winner, 1, "R9 tie goes to lower index");
        check(res_tie, 1, "R9 tie flagged");
        // R8 returning to voting clears the latch
        vote(4, 4'b0100);
        cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
        check(res_valid, 0, "R8 relocked");
        open_results();
        check(res_winner, 2, "R9 tie broken");
        check(res_tie, 0, "R9 no tie");
        // R6 remaining voters, then retry every voter
        vote(5, 4'b1000); vote(6, 4'b0001); vote(7, 4'b1000);
        for (int v = 0; v < 8; v++) present(v);
        open_results();
        check(res_total, 8, "R6 each voter once");
        // R11 reset clears everything
        cyc(1, 0, 0, 0, 0);
        rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
        vote(0, 4'b0001);
        open_results();
        check(res_total, 1, "R11 flags cleared by reset");
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad_n++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total_n, bad_n);
            $finish;
        end
    end
endmodule